// File: doc/BRIEF.md
# Floating-point control and status register unit

This block keeps the floating-point control/status word next to an arithmetic datapath. It decides, in the same cycle that an arithmetic operation completes, whether the result may be written back or whether an exception must trap. Each completing operation presents a six-bit exception vector. The unit replaces the cause field with that vector and ORs the five IEEE bits into the sticky flag field. It tests the new cause bits against the enable field. When the test hits, it raises `trap` and withholds `commit_en`, so the destination register is left untouched.

Software reaches the unit through a control-register move port. The same 5-bit index serves both reads and writes. Index 31 selects the status word. Index 0 is a revision register that reads as zero, and every other index also reads as zero. A write to index 31 stores the data with its reserved bits forced low and is checked for a trap at once. The unit also drives the 2-bit rounding mode and eight condition-code bits. Compare operations update one condition-code bit, picked by a 3-bit index, at completion. A 3-bit selector picks one of the eight bits for branch logic.

Status word layout: rounding [1:0]; flags [6:2]; enables [11:7]; cause [17:12], with cause[17] the unimplemented-operation bit; reserved [22:18]; condition code 0 at bit 23; a spare writable bit at 24; condition codes 1..7 at bits 25..31. Within each 5-bit group and in `op_exc[4:0]`, bit 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero and 4 invalid. `op_exc[5]` is the unimplemented-operation bit.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the status word reads as zero, so round-to-nearest is selected and the cause, flag, enable and condition-code fields are all zero.
- R2: Reads at index 0, and at any index other than 31, return zero. Writes to any index other than 31 leave the status word unchanged.
- R3: A write to index 31 stores the data with bits [22:18] forced to zero. A read of index 31 in the next cycle returns that masked value.
- R4: `rnd_mode` equals status bits [1:0]. The codes are 0 nearest, 1 toward zero, 2 toward +inf and 3 toward -inf.
- R5: On `op_done`, the cause field [17:12] is replaced by `op_exc[5:0]`.
- R6: On `op_done`, flags [6:2] become their old value ORed with `op_exc[4:0]`. No operation ever clears a flag.
- R7: During `op_done`, `trap` is high exactly when `(op_exc[4:0] & enables[11:7]) != 0` or `op_exc[5]` is set. The unimplemented-operation bit traps with no enable.
- R8: `commit_en` is high exactly when `op_done` is high and `trap` is low.
- R9: In the cycle of a write to index 31, `trap` is high exactly when the masked written word has `(bits[16:12] & bits[11:7]) != 0` or bit 17 set.
- R10: On `op_done` with `op_cc_we` and no trap, condition-code bit `op_cc_idx` takes `op_cc_val`. When the operation traps, the condition codes are unchanged.
- R11: `cc_vec[i]` is condition code i (bit 23 for i=0, bit 24+i otherwise). `cc_sel_bit` equals `cc_vec[cc_sel]`.
- R12: If a write to index 31 and `op_done` occur in the same cycle, the write alone sets the next status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_idx | input | 5 | Control register index for read and write |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read data (combinational) |
| op_done | input | 1 | Arithmetic operation completes this cycle |
| op_exc | input | 6 | Exceptions raised by the completing operation |
| op_cc_we | input | 1 | Completing operation is a compare |
| op_cc_idx | input | 3 | Condition code written by the compare |
| op_cc_val | input | 1 | Compare result |
| trap | output | 1 | Enabled exception present this cycle |
| commit_en | output | 1 | Result write-back allowed |
| rnd_mode | output | 2 | Current rounding mode |
| cc_vec | output | 8 | All condition-code bits |
| cc_sel | input | 3 | Condition-code selector |
| cc_sel_bit | output | 1 | Selected condition-code bit |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 5-bit index, status at index 31 and a zero revision value. With these values the exact bit layout the requirements name is reachable, including the reserved range and the split condition-code positions at 23 and 25..31. Random writes with random enable masks, mixed with random exception vectors, drive both the trapping and the non-trapping paths, including traps that leave the flag and condition-code fields mid-update. Directed cases cover the unimplemented bit with no enable set, all-ones writes against the reserved mask, and a write that collides with an operation.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_PINF = 2'd2,
    RND_NINF = 2'd3
  } rnd_mode_e;

  localparam int EXC_W    = 5;   // IEEE exception kinds
  localparam int FLG_LO   = 2;
  localparam int ENA_LO   = FLG_LO + EXC_W;
  localparam int CAU_LO   = ENA_LO + EXC_W;
  localparam int UNIMP_B  = CAU_LO + EXC_W;
  localparam int RSV_LO   = UNIMP_B + 1;
  localparam int RSV_HI   = 22;
  localparam int CC0_B    = 23;
  localparam int CC_N     = 8;

  // position of condition code i inside the status word
  function automatic int cc_pos(input int i);
    return (i == 0) ? CC0_B : 24 + i;
  endfunction
endpackage

// File: rtl/fcsr_trap_eval.sv
module fcsr_trap_eval
  import fcsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word_i,
  output logic          trap_o
);
  logic [EXC_W-1:0] hit;

  always_comb begin
    hit    = word_i[CAU_LO +: EXC_W] & word_i[ENA_LO +: EXC_W];
    trap_o = (|hit) | word_i[UNIMP_B];
  end
endmodule

// File: rtl/fcsr_next.sv
module fcsr_next
  import fcsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]  cur_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           op_i,
  input  logic [EXC_W:0] exc_i,
  input  logic           cc_we_i,
  input  logic [2:0]     cc_idx_i,
  input  logic           cc_val_i,
  input  logic           op_trap_i,
  output logic [DW-1:0]  masked_o,
  output logic [DW-1:0]  op_word_o,
  output logic [DW-1:0]  nxt_o,
  output logic           load_o
);
  localparam logic [DW-1:0] RSV_MASK =
    ((DW'(1) << (RSV_HI + 1)) - 1) & ~((DW'(1) << RSV_LO) - 1);

  logic [DW-1:0] op_nxt;

  always_comb begin
    masked_o  = wdata_i & ~RSV_MASK;
    op_word_o = cur_i;
    op_word_o[CAU_LO +: EXC_W + 1] = exc_i;
    op_nxt = op_word_o;
    op_nxt[FLG_LO +: EXC_W] = cur_i[FLG_LO +: EXC_W] | exc_i[EXC_W-1:0];
    for (int i = 0; i < CC_N; i++) begin
      if (cc_we_i && !op_trap_i && (cc_idx_i == 3'(i)))
        op_nxt[cc_pos(i)] = cc_val_i;
    end
    load_o = wr_i | op_i;
    if (wr_i)       nxt_o = masked_o;
    else if (op_i)  nxt_o = op_nxt;
    else            nxt_o = cur_i;
  end
endmodule

// File: rtl/fcsr_ccview.sv
module fcsr_ccview
  import fcsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   word_i,
  input  logic [2:0]      sel_i,
  output logic [CC_N-1:0] cc_o,
  output logic            bit_o
);
  for (genvar g = 0; g < CC_N; g++) begin : g_cc
    assign cc_o[g] = word_i[cc_pos(g)];
  end
  assign bit_o = cc_o[sel_i];
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          IDX_W     = 5,
  parameter int          CSR_IDX   = 31,
  parameter logic [31:0] REV_VALUE = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ctl_idx,
  input  logic             ctl_wr,
  input  logic [DW-1:0]    ctl_wdata,
  output logic [DW-1:0]    ctl_rdata,
  input  logic             op_done,
  input  logic [EXC_W:0]   op_exc,
  input  logic             op_cc_we,
  input  logic [2:0]       op_cc_idx,
  input  logic             op_cc_val,
  output logic             trap,
  output logic             commit_en,
  output logic [1:0]       rnd_mode,
  output logic [CC_N-1:0]  cc_vec,
  input  logic [2:0]       cc_sel,
  output logic             cc_sel_bit
);
  localparam logic [IDX_W-1:0] CSR_SEL = IDX_W'(CSR_IDX);

  logic [DW-1:0] csr_q, csr_d, masked_w, op_word;
  logic          csr_wr, load_en, op_trap_raw, wr_trap_raw, op_trap;
  rnd_mode_e     rm;

  assign csr_wr  = ctl_wr && (ctl_idx == CSR_SEL);
  assign op_trap = op_done && op_trap_raw;

  fcsr_next #(.DW(DW)) next_i (
    .cur_i(csr_q), .wr_i(csr_wr), .wdata_i(ctl_wdata), .op_i(op_done),
    .exc_i(op_exc), .cc_we_i(op_cc_we), .cc_idx_i(op_cc_idx),
    .cc_val_i(op_cc_val), .op_trap_i(op_trap), .masked_o(masked_w),
    .op_word_o(op_word), .nxt_o(csr_d), .load_o(load_en)
  );

  fcsr_trap_eval #(.DW(DW)) op_chk_i (.word_i(op_word),  .trap_o(op_trap_raw));
  fcsr_trap_eval #(.DW(DW)) wr_chk_i (.word_i(masked_w), .trap_o(wr_trap_raw));

  fcsr_ccview #(.DW(DW)) ccv_i (
    .word_i(csr_q), .sel_i(cc_sel), .cc_o(cc_vec), .bit_o(cc_sel_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       csr_q <= '0;
    else if (load_en) csr_q <= csr_d;
  end

  always_comb begin
    trap      = op_trap | (csr_wr && wr_trap_raw);
    commit_en = op_done && !trap;
    rm        = rnd_mode_e'(csr_q[1:0]);
    rnd_mode  = rm;
    if (ctl_idx == CSR_SEL)  ctl_rdata = csr_q;
    else if (ctl_idx == '0)  ctl_rdata = DW'(REV_VALUE);
    else                     ctl_rdata = '0;
  end

  // R3
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[RSV_HI:RSV_LO] == '0);

  // R5
  cause_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !csr_wr) |=> (csr_q[UNIMP_B:CAU_LO] == $past(op_exc)));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !csr_wr) |=>
      ((csr_q[ENA_LO-1:FLG_LO] & $past(csr_q[ENA_LO-1:FLG_LO]))
        == $past(csr_q[ENA_LO-1:FLG_LO])));

  // R7
  op_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && ((|(op_exc[EXC_W-1:0] & csr_q[CAU_LO-1:ENA_LO])) || op_exc[EXC_W]))
      |-> trap);

  // R10
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && trap && !csr_wr) |=> $stable(cc_vec));

  // R8
  commit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !commit_en);
endmodule

// File: tb/fcsr_unit_tb_top.sv
module fcsr_unit_tb_top;
  logic        clk, rst_n;
  logic [4:0]  ctl_idx;
  logic        ctl_wr;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic        op_done, op_cc_we, op_cc_val;
  logic [5:0]  op_exc;
  logic [2:0]  op_cc_idx, cc_sel;
  logic        trap, commit_en, cc_sel_bit;
  logic [1:0]  rnd_mode;
  logic [7:0]  cc_vec;

  int checks = 0, errors = 0;
  logic [31:0] m;    // model of the status word
  bit done_flag = 0;

  fcsr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_idx(ctl_idx), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .op_done(op_done),
    .op_exc(op_exc), .op_cc_we(op_cc_we), .op_cc_idx(op_cc_idx),
    .op_cc_val(op_cc_val), .trap(trap), .commit_en(commit_en),
    .rnd_mode(rnd_mode), .cc_vec(cc_vec), .cc_sel(cc_sel),
    .cc_sel_bit(cc_sel_bit)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] msk(input logic [31:0] w);
    return w & ~32'h007C_0000;
  endfunction
  function automatic logic trap_of(input logic [31:0] w);
    return (|(w[16:12] & w[11:7])) | w[17];
  endfunction
  function automatic int ccp(input int i);
    return (i == 0) ? 23 : 24 + i;
  endfunction
  function automatic logic [7:0] ccs(input logic [31:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = w[ccp(i)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_wr = 0; ctl_idx = 5'd31; ctl_wdata = '0; op_done = 0; op_exc = '0;
    op_cc_we = 0; op_cc_idx = '0; op_cc_val = 0; cc_sel = '0;
  endtask

  task automatic view();
    ctl_idx = 5'd31; #1;
    chk("R3 readback", ctl_rdata, m);
    chk("R4 rnd_mode", {30'd0, rnd_mode}, {30'd0, m[1:0]});
    chk("R11 cc_vec", {24'd0, cc_vec}, {24'd0, ccs(m)});
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    ctl_wr = 1; ctl_idx = idx; ctl_wdata = d; #1;
    chk((idx == 5'd31) ? "R9 write trap" : "R2 write trap",
        {31'd0, trap}, {31'd0, (idx == 5'd31) && trap_of(msk(d))});
    @(posedge clk);
    if (idx == 5'd31) m = msk(d);
    @(negedge clk); idle(); view();
  endtask

  task automatic do_op(input logic [5:0] e, input logic we, input logic [2:0] ci, input logic cv);
    logic [31:0] w; logic t;
    @(negedge clk);
    op_done = 1; op_exc = e; op_cc_we = we; op_cc_idx = ci; op_cc_val = cv; #1;
    w = m; w[17:12] = e; t = trap_of(w);
    chk("R7 op trap", {31'd0, trap}, {31'd0, t});
    chk("R8 commit", {31'd0, commit_en}, {31'd0, !t});
    @(posedge clk);
    w[6:2] = m[6:2] | e[4:0];
    if (we && !t) w[ccp(int'(ci))] = cv;
    m = w;
    @(negedge clk); idle(); view();
    chk("R5 cause", {26'd0, ctl_rdata[17:12]}, {26'd0, e});
    chk("R6 flags", {27'd0, ctl_rdata[6:2]}, {27'd0, m[6:2]});
  endtask

  initial begin
    process::self().srandom(32'd1234);
    idle(); m = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk("R1 reset word", ctl_rdata, 32'h0);
    chk("R1 reset rnd", {30'd0, rnd_mode}, 32'd0);
    ctl_idx = 5'd0; #1; chk("R2 rev reads zero", ctl_rdata, 32'h0);
    ctl_idx = 5'd7; #1; chk("R2 other reads zero", ctl_rdata, 32'h0);
    // R2 write elsewhere ignored
    do_write(5'd3, 32'hFFFF_FFFF);
    do_write(5'd0, 32'h0000_0003);
    // R3 reserved mask, R9 trap with all enables
    do_write(5'd31, 32'hFFFF_FFFF);
    do_write(5'd31, 32'h0000_0000);
    // R4 every rounding code
    for (int r = 0; r < 4; r++) do_write(5'd31, 32'(r));
    // R7 unimplemented traps with no enable
    do_op(6'b100000, 1'b1, 3'd2, 1'b1);
    // R6 sticky across ops with zero cause
    do_op(6'b000101, 1'b0, 3'd0, 1'b0);
    do_op(6'b000000, 1'b0, 3'd0, 1'b0);
    // R10 compare writes cc 0 and 7, R11 select
    do_op(6'b000000, 1'b1, 3'd0, 1'b1);
    do_op(6'b000000, 1'b1, 3'd7, 1'b1);
    for (int s = 0; s < 8; s++) begin
      cc_sel = 3'(s); #1;
      chk("R11 cc_sel_bit", {31'd0, cc_sel_bit}, {31'd0, m[ccp(s)]});
    end
    // R10 trapping compare leaves cc alone: enable overflow then raise it
    do_write(5'd31, m | 32'h0000_0200);
    do_op(6'b000100, 1'b1, 3'd3, 1'b1);
    // R12 write and op collide
    @(negedge clk);
    ctl_wr = 1; ctl_idx = 5'd31; ctl_wdata = 32'h0000_0002;
    op_done = 1; op_exc = 6'b010000;
    @(posedge clk); m = 32'h0000_0002;
    @(negedge clk); idle(); #1;
    chk("R12 write wins", ctl_rdata, m);
    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 3) == 0)
        do_write(($urandom_range(0, 4) == 0) ? 5'($urandom) : 5'd31, $urandom);
      else
        do_op(($urandom_range(0, 5) == 0) ? 6'($urandom) : {1'b0, 5'($urandom)},
              1'($urandom), 3'($urandom), 1'($urandom));
    end
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule